// File: doc/BRIEF.md
# Windowed B2 Signal-Degrade Detector

This block decides whether a received STM-0 line is in the signal-degrade state. An upstream parity checker hands it, once per frame, the number of B2 byte errors it found in that frame. The block adds these counts into a saturating accumulator. A monitoring window paces the accumulation. The window is a software-set number of milliseconds, and a free-running one-cycle millisecond tick advances it. When the window closes, the block compares the accumulated sum with a software-set threshold and updates the degrade flag. It then starts the next window from zero.

Software programs the window length and the threshold as two 24-bit fields, each split over three byte registers. A simple byte write port sets them, and a combinational read port returns them. A window length of zero switches monitoring off. Any configuration write restarts the window in progress, so a new setting is never judged against a partly filled window.

Top module: `sd_window_detector`

## Requirements
- R1: After reset all six configuration bytes read as 0x00 and `sd_flag` is 0.
- R2: The window length byte for bits 23:16 sits at address 0x23D, bits 15:8 at 0x23E and bits 7:0 at 0x23F. The threshold byte for bits 23:16 sits at 0x240, bits 15:8 at 0x241 and bits 7:0 at 0x242. `reg_rdata` returns the byte at `reg_addr`. Any other address reads 0x00, and a write to it changes no register.
- R3: Each `err_valid` cycle adds the 8-bit `err_count` into a 24-bit sum that saturates at 0xFFFFFF and never wraps.
- R4: With a nonzero length N, the window closes on the N-th `ms_tick` after it starts. `sd_flag` takes its new value in the cycle after that closing tick.
- R5: At a window close `sd_flag` becomes 1 only if the window's sum is strictly greater than the threshold. A sum equal to the threshold gives 0.
- R6: At a window close whose sum does not exceed the threshold, `sd_flag` is cleared.
- R7: While the window length is zero, `sd_flag` is 0 one cycle later, and neither ticks nor errors have any effect.
- R8: A write to any of the six configuration addresses restarts the window: the tick count and the error sum both return to zero. `sd_flag` is left unchanged, unless the new length is zero.
- R9: An error count presented in the same cycle as the closing tick is counted in the window that is closing. The next window starts from a sum of zero.
- R10: `sd_flag` changes only at a window close or when monitoring is switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Configuration write strobe |
| reg_addr | input | 12 | Configuration byte address (write and read) |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration read data for `reg_addr` |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| err_valid | input | 1 | Per-frame error count strobe |
| err_count | input | 8 | B2 byte errors found in the frame |
| sd_flag | output | 1 | Signal-degrade defect flag |

## Verification
Two events can fall in the same cycle: a frame's error count arriving with its strobe, and the closing millisecond tick. The bench drives both in one cycle and picks a threshold so that the flag is set only if that last count is included. It then runs an error-free window, which must clear the flag; this shows that the count was not carried into the next window. A configuration write that lands while a window is partly filled is a second case of this kind. The bench judges it by threshold choices that only an uncleared counter or an uncleared sum would trip.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int BYTE_W      = 8;
  localparam int FIELD_BYTES = 3;
  localparam int FIELD_W     = BYTE_W * FIELD_BYTES;
  localparam int ERR_W       = 8;
  localparam int ADDR_W      = 12;
  localparam logic [ADDR_W-1:0] WIN_BASE = 12'h23D;
  localparam logic [ADDR_W-1:0] THR_BASE = 12'h240;

  // Saturating add of a frame error count into the window sum.
  function automatic logic [FIELD_W-1:0] sat_add(input logic [FIELD_W-1:0] acc,
                                                 input logic [ERR_W-1:0]   inc);
    logic [FIELD_W:0] wide;
    wide = {1'b0, acc} + {{(FIELD_W+1-ERR_W){1'b0}}, inc};
    return wide[FIELD_W] ? {FIELD_W{1'b1}} : wide[FIELD_W-1:0];
  endfunction

  // Degrade decision: strictly greater than the threshold.
  function automatic logic degrade(input logic [FIELD_W-1:0] sum,
                                   input logic [FIELD_W-1:0] thr);
    return sum > thr;
  endfunction
endpackage

// File: rtl/sdw_regfile.sv
module sdw_regfile
  import sdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [FIELD_W-1:0] win_len,
  output logic [FIELD_W-1:0] thr,
  output logic              cfg_write
);
  logic [FIELD_BYTES-1:0] win_hit, thr_hit;

  // Byte k holds field bits [8k+7:8k]; the most significant byte sits at the base.
  for (genvar k = 0; k < FIELD_BYTES; k++) begin : g_byte
    assign win_hit[k] = (addr == WIN_BASE + ADDR_W'(FIELD_BYTES - 1 - k));
    assign thr_hit[k] = (addr == THR_BASE + ADDR_W'(FIELD_BYTES - 1 - k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_len[k*BYTE_W +: BYTE_W] <= '0;
        thr[k*BYTE_W +: BYTE_W]     <= '0;
      end else if (wr_en) begin
        if (win_hit[k]) win_len[k*BYTE_W +: BYTE_W] <= wdata;
        if (thr_hit[k]) thr[k*BYTE_W +: BYTE_W]     <= wdata;
      end
    end
  end

  assign cfg_write = wr_en && ((|win_hit) || (|thr_hit));

  always_comb begin
    rdata = '0;
    for (int k = 0; k < FIELD_BYTES; k++) begin
      if (win_hit[k]) rdata = win_len[k*BYTE_W +: BYTE_W];
      if (thr_hit[k]) rdata = thr[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sdw_window_timer.sv
module sdw_window_timer
  import sdw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] win_len,
  input  logic               restart,
  input  logic               ms_tick,
  output logic               enabled,
  output logic               window_close,
  output logic [FIELD_W-1:0] ms_cnt
);
  logic last_ms;

  assign enabled      = |win_len;
  assign last_ms      = (ms_cnt == win_len - 1'b1);
  assign window_close = enabled && !restart && ms_tick && last_ms;

  always_ff @(posedge clk) begin
    if (!rst_n)                   ms_cnt <= '0;
    else if (restart || !enabled) ms_cnt <= '0;
    else if (ms_tick)             ms_cnt <= last_ms ? '0 : ms_cnt + 1'b1;
  end
endmodule

// File: rtl/sdw_err_accum.sv
module sdw_err_accum
  import sdw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               window_close,
  input  logic               err_valid,
  input  logic [ERR_W-1:0]   err_count,
  output logic [FIELD_W-1:0] closing_sum,
  output logic [FIELD_W-1:0] sum_q
);
  // The current frame's count is included, so a count arriving with the closing tick is judged.
  assign closing_sum = sat_add(sum_q, err_valid ? err_count : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                     sum_q <= '0;
    else if (clear || window_close) sum_q <= '0;
    else                            sum_q <= closing_sum;
  end
endmodule

// File: rtl/sd_window_detector.sv
module sd_window_detector
  import sdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              ms_tick,
  input  logic              err_valid,
  input  logic [ERR_W-1:0]  err_count,
  output logic              sd_flag
);
  logic [FIELD_W-1:0] win_len, thr, ms_cnt, closing_sum, sum_q;
  logic               cfg_write, enabled, window_close;

  sdw_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .win_len(win_len), .thr(thr),
    .cfg_write(cfg_write)
  );

  sdw_window_timer u_timer (
    .clk(clk), .rst_n(rst_n), .win_len(win_len), .restart(cfg_write),
    .ms_tick(ms_tick), .enabled(enabled), .window_close(window_close),
    .ms_cnt(ms_cnt)
  );

  sdw_err_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clear(cfg_write || !enabled),
    .window_close(window_close), .err_valid(err_valid), .err_count(err_count),
    .closing_sum(closing_sum), .sum_q(sum_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            sd_flag <= 1'b0;
    else if (!enabled)     sd_flag <= 1'b0;
    else if (window_close) sd_flag <= degrade(closing_sum, thr);
  end
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker
  import sdw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [FIELD_W-1:0] win_len,
  input logic [FIELD_W-1:0] thr,
  input logic               cfg_write,
  input logic               window_close,
  input logic [FIELD_W-1:0] ms_cnt,
  input logic [FIELD_W-1:0] sum_q,
  input logic [FIELD_W-1:0] closing_sum,
  input logic               sd_flag
);
  assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != '0) |-> (ms_cnt < win_len));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_close && !cfg_write && win_len != '0) |=> (sum_q >= $past(sum_q)));

  assert_strict_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    window_close |=> (sd_flag == ($past(closing_sum) > $past(thr))));

  assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == '0) |=> !sd_flag);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write |=> (ms_cnt == '0 && sum_q == '0));

  assert_fresh_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    window_close |=> (sum_q == '0));

  assert_flag_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_close && win_len != '0) |=> $stable(sd_flag));
endmodule

bind sd_window_detector sdw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .win_len(win_len), .thr(thr), .cfg_write(cfg_write),
  .window_close(window_close), .ms_cnt(ms_cnt), .sum_q(sum_q),
  .closing_sum(closing_sum), .sd_flag(sd_flag)
);

// File: tb/tb_sd_window_detector.sv
module tb_sd_window_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ms_tick = 1'b0;
  logic        err_valid = 1'b0;
  logic [7:0]  err_count = '0;
  logic        sd_flag;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  sd_window_detector dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ms_tick(ms_tick),
    .err_valid(err_valid), .err_count(err_count), .sd_flag(sd_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, driven at the falling edge; state after the edge is visible on return.
  task automatic cyc(input logic v, input logic [7:0] cnt, input logic tk);
    err_valid = v; err_count = cnt; ms_tick = tk;
    @(negedge clk);
    err_valid = 1'b0; err_count = '0; ms_tick = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, int'(reg_rdata), int'(exp));
  endtask

  task automatic set_fields(input logic [23:0] len, input logic [23:0] th);
    wr(12'h23D, len[23:16]); wr(12'h23E, len[15:8]); wr(12'h23F, len[7:0]);
    wr(12'h240, th[23:16]);  wr(12'h241, th[15:8]);  wr(12'h242, th[7:0]);
  endtask

  task automatic t_reset;
    check("R1 flag", int'(sd_flag), 0);
    for (int a = 'h23D; a <= 'h242; a++) rd_check("R1 reg", 12'(a), 8'h00);
  endtask

  task automatic t_regmap;
    set_fields(24'hA1B2C3, 24'hD4E5F6);
    wr(12'h23C, 8'h77); wr(12'h243, 8'h88);
    rd_check("R2 win hi", 12'h23D, 8'hA1); rd_check("R2 win mid", 12'h23E, 8'hB2);
    rd_check("R2 win lo", 12'h23F, 8'hC3); rd_check("R2 thr hi", 12'h240, 8'hD4);
    rd_check("R2 thr mid", 12'h241, 8'hE5); rd_check("R2 thr lo", 12'h242, 8'hF6);
    rd_check("R2 unmapped below", 12'h23C, 8'h00);
    rd_check("R2 unmapped above", 12'h243, 8'h00);
  endtask

  task automatic t_equal_and_exceed;
    set_fields(24'd4, 24'd10);
    cyc(1, 8'd4, 0); cyc(1, 8'd6, 0);
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    check("R4 open before last tick", int'(sd_flag), 0);
    cyc(0, 0, 1);
    check("R5 equal to threshold", int'(sd_flag), 0);
    cyc(1, 8'd11, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    check("R10 no change mid-window", int'(sd_flag), 0);
    cyc(0, 0, 1);
    check("R5 exceeds threshold", int'(sd_flag), 1);
  endtask

  task automatic t_clear;
    cyc(1, 8'd3, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    check("R10 set flag held mid-window", int'(sd_flag), 1);
    cyc(0, 0, 1);
    check("R6 clear at close", int'(sd_flag), 0);
  endtask

  task automatic t_collision;
    set_fields(24'd2, 24'd5);
    cyc(1, 8'd5, 1);
    cyc(1, 8'd1, 1);
    check("R9 count with closing tick", int'(sd_flag), 1);
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R9 next window from zero", int'(sd_flag), 0);
  endtask

  task automatic t_restart;
    set_fields(24'd3, 24'd1);
    cyc(1, 8'd5, 1); cyc(0, 0, 1);
    wr(12'h242, 8'd1);
    check("R8 flag kept on write", int'(sd_flag), 0);
    cyc(1, 8'd1, 1);
    check("R8 counter restarted", int'(sd_flag), 0);
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R8 sum restarted", int'(sd_flag), 0);
  endtask

  task automatic t_zero_len;
    set_fields(24'd1, 24'd0);
    cyc(1, 8'd1, 1);
    check("R7 setup flag", int'(sd_flag), 1);
    wr(12'h23F, 8'd0);
    cyc(0, 0, 0);
    check("R7 off clears flag", int'(sd_flag), 0);
    for (int i = 0; i < 4; i++) cyc(1, 8'd200, 1);
    check("R7 off ignores input", int'(sd_flag), 0);
  endtask

  task automatic t_saturate;
    set_fields(24'd1, 24'hFFFFFE);
    for (int i = 0; i < 65794; i++) cyc(1, 8'd255, 0);
    cyc(0, 0, 1);
    check("R3 saturates above threshold", int'(sd_flag), 1);
    wr(12'h242, 8'hFF);
    for (int i = 0; i < 65794; i++) cyc(1, 8'd255, 0);
    cyc(0, 0, 1);
    check("R3 saturates at max, equal", int'(sd_flag), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_equal_and_exceed();
    t_clear();
    t_collision();
    t_restart();
    t_zero_len();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule